// File: doc/BRIEF.md
# Masked I/O Address Trap Monitor

This block holds a bank of I/O address watchers. Each watcher owns a 16-bit base address, a 4-bit low-order don't-care mask and an enable. On every processor I/O cycle the block compares the address against each enabled watcher. A hit also needs the cycle to be positively decoded by some agent. Each hit sets a sticky status bit, and the system management interrupt line stays high while any enabled watcher has its status set. Software clears a status bit by writing 1 to it.

The block also qualifies cycles bound for the LPC bus. Such a cycle goes to LPC only if none of the enabled watchers it hits withholds forwarding. Cycles to permitted internal targets always complete, and the block raises a trap for them in the same way. All configuration is written through a small write-only register port. Status and interrupt come out on dedicated outputs that are updated on the same clock edge.

Top module: `io_trap_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, every base, mask, enable, forward-enable and status bit clears, so after reset `trap_status`, `smi` and `lpc_fwd` are all 0.
- R2: A watcher compares address bits 15:4 exactly against its base. A change in any of those bits prevents a hit, whatever the mask.
- R3: A mask bit at 1 removes the matching address bit from bits 3:0 of the compare. Watcher n takes its mask from bits 4n+3:4n of the mask register. Example: base 1230h with mask 0011b hits 1230h to 1233h.
- R4: A watcher whose enable bit is 0 never sets its status bit.
- R5: A cycle sets status only when `io_valid` and `io_decoded` are both 1 at the clock edge.
- R6: Every enabled watcher hit by the same cycle sets its own status bit at the same edge.
- R7: A status bit stays at 1 until a write of 1 to that bit at select 6. When a set and a clear of the same bit fall in one cycle, the set wins.
- R8: `smi` equals the OR over watchers of status AND enable, both taken after the same edge. Clearing an enable drops its contribution but leaves the status bit intact.
- R9: A hit on a cycle whose target class is 0 (other device) or 1 (permitted internal) sets status, and `lpc_fwd` stays 0.
- R10: One clock after a valid, decoded cycle with target class 2 (LPC), `lpc_fwd` is 1 only if every enabled watcher it hits has its forward-enable bit set, or if no enabled watcher is hit. In every other cycle `lpc_fwd` is 0.
- R11: Register selects are as follows. Selects 0 to 3 hold the base of watchers 0 to 3. Select 4 is the mask register. Select 5 is the control register, with enables in bits 3:0 and forward-enables in bits 7:4. Select 6 is the write-1-to-clear status. A write changes nothing else, and the cycle compare uses the values held before a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (R11) |
| reg_wdata | input | 16 | Register write data |
| io_valid | input | 1 | I/O cycle present this clock |
| io_addr | input | 16 | I/O cycle address |
| io_decoded | input | 1 | Cycle is positively decoded by some agent |
| io_target | input | 2 | Target class: 0 other, 1 internal, 2 LPC |
| trap_status | output | 4 | Sticky per-watcher trap status |
| smi | output | 1 | System management interrupt request |
| lpc_fwd | output | 1 | Forward the previous LPC-bound cycle to LPC |

## Verification
A corrupted base, mask or enable register shows on `trap_status` one clock after the next cycle aimed at the affected window, or aimed just outside it. A stuck or lost status bit shows at once on `trap_status`, and on `smi` whenever that watcher is enabled. A wrong forward-enable stays hidden until an LPC-bound cycle hits that watcher, and `lpc_fwd` then shows it one clock later. For this reason the reference model is compared against all three outputs on every clock, under random addresses clustered around the programmed windows.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;
  typedef enum logic [1:0] {
    TGT_EXT = 2'd0,
    TGT_INT = 2'd1,
    TGT_LPC = 2'd2
  } io_target_e;
endpackage

// File: rtl/io_trap_regs.sv
module io_trap_regs #(
  parameter int NUM_MON = 4,
  parameter int ADDR_W  = 16,
  parameter int MASK_W  = 4,
  parameter int DATA_W  = 16,
  parameter int SEL_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_wr,
  input  logic [SEL_W-1:0]          reg_sel,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [NUM_MON*ADDR_W-1:0] base_q,
  output logic [NUM_MON*MASK_W-1:0] mask_q,
  output logic [NUM_MON-1:0]        en_q,
  output logic [NUM_MON-1:0]        fwd_en_q,
  output logic [NUM_MON-1:0]        en_nxt,
  output logic [NUM_MON-1:0]        clr_req
);
  localparam int SEL_MASK = NUM_MON;
  localparam int SEL_CTRL = NUM_MON + 1;
  localparam int SEL_STAT = NUM_MON + 2;

  logic wr_mask, wr_ctrl, wr_stat;
  assign wr_mask = reg_wr && (reg_sel == SEL_W'(SEL_MASK));
  assign wr_ctrl = reg_wr && (reg_sel == SEL_W'(SEL_CTRL));
  assign wr_stat = reg_wr && (reg_sel == SEL_W'(SEL_STAT));

  genvar g;
  generate
    for (g = 0; g < NUM_MON; g++) begin : g_base
      always_ff @(posedge clk) begin
        if (rst)
          base_q[g*ADDR_W +: ADDR_W] <= '0;
        else if (reg_wr && (reg_sel == SEL_W'(g)))
          base_q[g*ADDR_W +: ADDR_W] <= reg_wdata[ADDR_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[NUM_MON*MASK_W-1:0];
  end

  always_comb begin
    en_nxt = en_q;
    if (wr_ctrl) en_nxt = reg_wdata[NUM_MON-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      fwd_en_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (wr_ctrl) fwd_en_q <= reg_wdata[2*NUM_MON-1:NUM_MON];
    end
  end

  assign clr_req = wr_stat ? reg_wdata[NUM_MON-1:0] : '0;
endmodule

// File: rtl/io_trap_match.sv
module io_trap_match #(
  parameter int ADDR_W = 16,
  parameter int MASK_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [MASK_W-1:0] mask,
  output logic              hit
);
  logic [ADDR_W-1:0] care;
  assign care = ~{{(ADDR_W-MASK_W){1'b0}}, mask};
  assign hit  = ((addr ^ base) & care) == '0;
endmodule

// File: rtl/io_trap_status.sv
module io_trap_status #(
  parameter int NUM_MON = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_ok,
  input  logic               is_lpc,
  input  logic [NUM_MON-1:0] hit,
  input  logic [NUM_MON-1:0] en_q,
  input  logic [NUM_MON-1:0] fwd_en_q,
  input  logic [NUM_MON-1:0] en_nxt,
  input  logic [NUM_MON-1:0] clr_req,
  output logic [NUM_MON-1:0] status_q,
  output logic               smi_q,
  output logic               lpc_fwd_q
);
  logic [NUM_MON-1:0] trap, status_d;
  logic               blocked;

  assign trap     = hit & en_q & {NUM_MON{cyc_ok}};
  assign status_d = (status_q & ~clr_req) | trap;
  assign blocked  = |(trap & ~fwd_en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      smi_q     <= 1'b0;
      lpc_fwd_q <= 1'b0;
    end else begin
      status_q  <= status_d;
      smi_q     <= |(status_d & en_nxt);
      lpc_fwd_q <= cyc_ok && is_lpc && !blocked;
    end
  end
endmodule

// File: rtl/io_trap_monitor.sv
module io_trap_monitor #(
  parameter int NUM_MON = 4,
  parameter int ADDR_W  = 16,
  parameter int MASK_W  = 4,
  parameter int DATA_W  = 16,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [SEL_W-1:0]   reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               io_valid,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic               io_decoded,
  input  logic [1:0]         io_target,
  output logic [NUM_MON-1:0] trap_status,
  output logic               smi,
  output logic               lpc_fwd
);
  import io_trap_pkg::*;

  logic [NUM_MON*ADDR_W-1:0] base_q;
  logic [NUM_MON*MASK_W-1:0] mask_q;
  logic [NUM_MON-1:0]        en_q, fwd_en_q, en_nxt, clr_req, hit;
  logic                      cyc_ok, is_lpc;

  assign cyc_ok = io_valid && io_decoded;
  assign is_lpc = (io_target == TGT_LPC);

  io_trap_regs #(
    .NUM_MON(NUM_MON), .ADDR_W(ADDR_W), .MASK_W(MASK_W),
    .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .base_q(base_q), .mask_q(mask_q),
    .en_q(en_q), .fwd_en_q(fwd_en_q), .en_nxt(en_nxt), .clr_req(clr_req)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_MON; g++) begin : g_mon
      io_trap_match #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_match (
        .addr(io_addr),
        .base(base_q[g*ADDR_W +: ADDR_W]),
        .mask(mask_q[g*MASK_W +: MASK_W]),
        .hit (hit[g])
      );
    end
  endgenerate

  io_trap_status #(.NUM_MON(NUM_MON)) u_status (
    .clk(clk), .rst(rst), .cyc_ok(cyc_ok), .is_lpc(is_lpc), .hit(hit),
    .en_q(en_q), .fwd_en_q(fwd_en_q), .en_nxt(en_nxt), .clr_req(clr_req),
    .status_q(trap_status), .smi_q(smi), .lpc_fwd_q(lpc_fwd)
  );
endmodule

// File: rtl/io_trap_checker.sv
module io_trap_checker #(
  parameter int NUM_MON = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic               io_valid,
  input logic               io_decoded,
  input logic [1:0]         io_target,
  input logic [NUM_MON-1:0] trap_status,
  input logic               smi,
  input logic               lpc_fwd
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (trap_status == '0) && !smi && !lpc_fwd);

  assert_no_set_without_decode_R5: assert property (@(posedge clk) disable iff (rst)
    !(io_valid && io_decoded) |=> ((trap_status & ~$past(trap_status)) == '0));

  assert_status_holds_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!io_valid && !reg_wr) |=> $stable(trap_status));

  assert_smi_needs_status_R8: assert property (@(posedge clk) disable iff (rst)
    (trap_status == '0) |-> !smi);

  assert_fwd_only_after_lpc_R10: assert property (@(posedge clk) disable iff (rst)
    !(io_valid && io_decoded && io_target == 2'd2) |=> !lpc_fwd);
endmodule

bind io_trap_monitor io_trap_checker #(.NUM_MON(NUM_MON)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .io_valid(io_valid),
  .io_decoded(io_decoded), .io_target(io_target),
  .trap_status(trap_status), .smi(smi), .lpc_fwd(lpc_fwd)
);

// File: tb/io_trap_monitor_test.sv
`timescale 1ns/1ps
module io_trap_monitor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        io_valid = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_decoded = 1'b0;
  logic [1:0]  io_target = '0;
  logic [3:0]  trap_status;
  logic        smi, lpc_fwd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  io_trap_monitor uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .io_valid(io_valid), .io_addr(io_addr),
    .io_decoded(io_decoded), .io_target(io_target),
    .trap_status(trap_status), .smi(smi), .lpc_fwd(lpc_fwd)
  );

  // behavioural reference model
  int m_base[4];
  int m_mask[4];
  int m_en[4];
  int m_fwd[4];
  int m_stat[4];
  int m_smi, m_lpc;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_base[i] = 0; m_mask[i] = 0; m_en[i] = 0; m_fwd[i] = 0; m_stat[i] = 0;
      end
      m_smi = 0; m_lpc = 0;
    end else begin
      int allow;
      allow = 1;
      for (int i = 0; i < 4; i++) begin
        int diff;
        diff = (io_addr ^ m_base[i]) & ~m_mask[i] & 16'hFFFF;
        if (io_valid && io_decoded && m_en[i] == 1 && diff == 0) begin
          if (reg_wr && reg_sel == 3'd6 && reg_wdata[i]) m_stat[i] = 1;
          m_stat[i] = 1;
          if (m_fwd[i] == 0) allow = 0;
        end else if (reg_wr && reg_sel == 3'd6 && reg_wdata[i]) begin
          m_stat[i] = 0;
        end
      end
      m_lpc = (io_valid && io_decoded && io_target == 2'd2 && allow == 1) ? 1 : 0;
      if (reg_wr) begin
        if (reg_sel < 3'd4) m_base[reg_sel] = reg_wdata;
        else if (reg_sel == 3'd4)
          for (int i = 0; i < 4; i++) m_mask[i] = (reg_wdata >> (4*i)) & 15;
        else if (reg_sel == 3'd5)
          for (int i = 0; i < 4; i++) begin
            m_en[i]  = reg_wdata[i];
            m_fwd[i] = reg_wdata[4+i];
          end
      end
      m_smi = 0;
      for (int i = 0; i < 4; i++) if (m_stat[i] == 1 && m_en[i] == 1) m_smi = 1;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_status();
    int v;
    v = 0;
    for (int i = 0; i < 4; i++) if (m_stat[i] == 1) v |= (1 << i);
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R7 status vs model", int'(trap_status), model_status());
      check("R8 smi vs model", int'(smi), m_smi);
      check("R10 lpc_fwd vs model", int'(lpc_fwd), m_lpc);
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cyc(input logic [15:0] a, input logic dec, input logic [1:0] tgt);
    @(negedge clk);
    io_valid = 1'b1; io_addr = a; io_decoded = dec; io_target = tgt;
    @(negedge clk);
    io_valid = 1'b0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status after reset", int'(trap_status), 0);
    check("R1 smi after reset", int'(smi), 0);
    check("R1 lpc_fwd after reset", int'(lpc_fwd), 0);
    rst = 1'b0;
    cyc(16'h0000, 1'b1, 2'd0);
    check("R4 reset enables off", int'(trap_status), 0);

    wr(3'd0, 16'h1230); wr(3'd1, 16'h1234); wr(3'd2, 16'h1230); wr(3'd3, 16'h8000);
    wr(3'd4, 16'h0F03);           // R11 mask nibbles: m0=3 m1=0 m2=F m3=0
    wr(3'd5, 16'h0007);           // enables 0..2, no forward
    cyc(16'h1233, 1'b1, 2'd0);
    check("R3 R6 masked hits", int'(trap_status), 4'b0101);
    check("R8 smi raised", int'(smi), 1);
    check("R9 no fwd for other target", int'(lpc_fwd), 0);
    wr(3'd6, 16'h0005);
    check("R7 w1c clears", int'(trap_status), 0);
    check("R8 smi drops", int'(smi), 0);
    cyc(16'h1234, 1'b0, 2'd0);
    check("R5 undecoded ignored", int'(trap_status), 0);
    cyc(16'h8000, 1'b1, 2'd0);
    check("R4 disabled monitor", int'(trap_status), 0);
    cyc(16'h1234, 1'b1, 2'd2);
    check("R6 two hits", int'(trap_status), 4'b0110);
    check("R10 fwd withheld", int'(lpc_fwd), 0);
    wr(3'd6, 16'h000F);
    wr(3'd5, 16'h0067);
    cyc(16'h1234, 1'b1, 2'd2);
    check("R10 fwd allowed", int'(lpc_fwd), 1);
    wr(3'd6, 16'h000F);
    cyc(16'h2230, 1'b1, 2'd2);
    check("R2 upper bit differs", int'(trap_status), 0);
    check("R10 fwd on no hit", int'(lpc_fwd), 1);
    cyc(16'h1231, 1'b1, 2'd1);
    check("R9 internal target traps", int'(trap_status), 4'b0101);
    check("R9 internal no fwd", int'(lpc_fwd), 0);
    wr(3'd5, 16'h0000);
    check("R8 smi off when disabled", int'(smi), 0);
    check("R8 status kept", int'(trap_status), 4'b0101);
    wr(3'd5, 16'h0007);
    @(negedge clk);
    io_valid = 1'b1; io_addr = 16'h1231; io_decoded = 1'b1; io_target = 2'd0;
    reg_wr = 1'b1; reg_sel = 3'd6; reg_wdata = 16'h0001;
    @(negedge clk);
    io_valid = 1'b0; reg_wr = 1'b0;
    check("R7 set wins over clear", int'(trap_status), 4'b0101);

    // random phase against the model
    wr(3'd5, 16'h00A7);
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      io_valid   = ($urandom % 4) != 0;
      io_decoded = ($urandom % 5) != 0;
      io_target  = 2'($urandom % 3);
      io_addr    = (($urandom % 2) == 0) ? 16'h1230 : 16'h8000;
      io_addr    = io_addr ^ 16'($urandom % 16);
      if (($urandom % 6) == 0) io_addr = io_addr ^ 16'(1 << (4 + $urandom % 12));
      reg_wr     = ($urandom % 6) == 0;
      reg_sel    = 3'($urandom % 7);
      reg_wdata  = 16'($urandom);
      if (reg_sel < 3'd4 && ($urandom % 2) == 0) reg_wdata = 16'h1230;
    end
    @(negedge clk);
    io_valid = 1'b0; reg_wr = 1'b0;
    @(negedge clk);
    done = 1;
    report();
  end
endmodule